// File: doc/BRIEF.md
# Dual-Pattern Overlapping Serial Sequence Detector

This block takes in a one-bit serial stream, one bit on each rising clock edge. It flags every place where the four most recent bits form either `1011` or `1101`. The flag is Mealy-type: it is built from the stored history together with the bit currently on the input. A match is therefore reported in the same cycle as its last bit, before that bit is clocked in.

The state is a three-stage history register, not an encoded state machine. Each new bit enters the newest stage and older bits move one stage toward the oldest end. Both target patterns begin and end with a `1`, and their two inner bits always differ. Because of this, a single product term covers both patterns: the present bit, AND the oldest stored bit, AND the XOR of the two younger stored bits. Matches may overlap, so the bits that close one pattern can open the next.

Top module: `dual_pattern_detector`

## Requirements
- R1: When the three stored bits (oldest first) are `101` and the present input is `1`, `det` is 1 in that same cycle.
- R2: When the three stored bits (oldest first) are `110` and the present input is `1`, `det` is 1 in that same cycle.
- R3: Detection overlaps. The stream `1011011` after reset flags its 4th, 6th and 7th bits. The stream `11011` flags its 4th and 5th bits.
- R4: For every other 4-bit window (present bit last), `det` is 0. Every window value from `0000` to `1111` is covered.
- R5: Reset is synchronous and active high, and it clears the history to zeros. No detection can occur on the first three bits after reset, and a partial match that was in progress before reset is discarded.
- R6: Exactly one bit is consumed per clock, with no enable. The newest bit enters the least significant stage, and each older bit moves one stage toward the most significant end.
- R7: Whenever the present input bit is 0, `det` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, one per cycle |
| det | output | 1 | Combinational match flag for the window ending with `din` |

## Verification
Two short streams each isolate one pattern, and stepping through all sixteen windows after a fresh reset separates the two real matches from their nearest look-alikes. The overlapping streams `1011011` and `11011` show whether the history keeps its bits after a hit or throws them away. A partial `110` cut off by reset, followed by a `1`, exposes a reset that fails to clear the history. Long runs of zeros and ones, plus a pseudo-random stream, catch a reversed shift direction and a wrongly chosen stage in the XOR term.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
    localparam int HIST_W = 3;
    localparam int WIN_W  = HIST_W + 1;

    typedef struct packed {
        logic [HIST_W-1:0] bits;
    } hist_s;
endpackage

// File: rtl/dpd_history.sv
module dpd_history
    import dpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    output logic [HIST_W-1:0] hist
);
    hist_s state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.bits = '0;
        end else begin
            state_d.bits = {state_q.bits[HIST_W-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign hist = state_q.bits;

    // R6: the newest stage takes the bit seen on the previous cycle
    assert_shift_in_R6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> hist[0] == $past(din));

    // R6: the older stages take the previous younger stages
    assert_shift_age_R6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> hist[HIST_W-1:1] == $past(hist[HIST_W-2:0]));

    // R5: a reset cycle leaves the history all zero
    assert_reset_clear_R5: assert property (@(posedge clk)
        rst |=> hist == '0);
endmodule

// File: rtl/dpd_match.sv
module dpd_match
    import dpd_pkg::*;
(
    input  logic [HIST_W-1:0] hist,
    input  logic              din,
    output logic              hit
);
    logic oldest_one;
    logic inner_differ;

    always_comb begin
        oldest_one   = hist[HIST_W-1];
        inner_differ = hist[1] ^ hist[0];
        hit          = din & oldest_one & inner_differ;
    end
endmodule

// File: rtl/dual_pattern_detector.sv
module dual_pattern_detector
    import dpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic det
);
    logic [HIST_W-1:0] hist;

    dpd_history u_history (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .hist (hist)
    );

    dpd_match u_match (
        .hist (hist),
        .din  (din),
        .hit  (det)
    );

    // Counts the bits accepted since reset (saturating) for the assertions below.
    logic [1:0] since_rst_d, since_rst_q;

    always_comb begin
        since_rst_d = since_rst_q;
        if (rst) begin
            since_rst_d = 2'd0;
        end else if (since_rst_q != 2'd3) begin
            since_rst_d = since_rst_q + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        since_rst_q <= since_rst_d;
    end

    assert_pattern_a_R1: assert property (@(posedge clk) disable iff (rst)
        (din && hist == 3'b101) |-> det);

    assert_pattern_b_R2: assert property (@(posedge clk) disable iff (rst)
        (din && hist == 3'b110) |-> det);

    assert_quiet_start_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q != 2'd3) |-> !det);

    assert_zero_input_R7: assert property (@(posedge clk) disable iff (rst)
        !din |-> !det);
endmodule

// File: tb/dual_pattern_detector_tb.sv
module dual_pattern_detector_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic det;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit    exp_q[$];
    string req_q[$];
    logic [2:0] model_hist = 3'b000;

    always #4 clk = ~clk;

    dual_pattern_detector u_dut (
        .clk (clk),
        .rst (rst),
        .din (din),
        .det (det)
    );

    // Driver: one bit per cycle, the expected flag comes from the 4-bit window.
    task automatic send_bit(input bit b, input string req);
        logic [3:0] win;
        @(negedge clk);
        rst = 1'b0;
        din = b;
        win = {model_hist, b};
        exp_q.push_back((win == 4'b1011) || (win == 4'b1101));
        req_q.push_back(req);
        model_hist = {model_hist[1:0], b};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        din = 1'b0;
        model_hist = 3'b000;
    endtask

    task automatic send_str(input string s, input string req);
        for (int i = 0; i < s.len(); i++) send_bit(s[i] == "1", req);
    endtask

    // Monitor: compares the combinational flag mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                bit e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                checks++;
                if (det !== e) begin
                    fails++;
                    $display("FAIL %s: det=%b expected=%b at %0t", r, det, e, $time);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        do_reset();
        send_bit(1'b0, "R5 reset state");
        send_str("111", "R5 first bits quiet");
        // R5: partial 110 is discarded by reset
        do_reset();
        send_str("110", "R5 prefix");
        do_reset();
        send_bit(1'b1, "R5 no match across reset");
        do_reset();
        send_str("1011", "R1");
        do_reset();
        send_str("1101", "R2");
        do_reset();
        send_str("1011011", "R3 overlap a");
        do_reset();
        send_str("11011", "R3 overlap b");
        // R4: every window value after a fresh reset
        for (int v = 0; v < 16; v++) begin
            do_reset();
            for (int k = 3; k >= 0; k--) send_bit(v[k], "R4 window");
        end
        do_reset();
        for (int i = 0; i < 24; i++) send_bit(1'b0, "R7 zero run");
        for (int i = 0; i < 24; i++) send_bit(1'b1, "R4 one run");
        send_str("0101101011", "R6 mixed");
        lfsr = 8'hA5;
        for (int i = 0; i < 300; i++) begin
            send_bit(lfsr[0], "R6 random");
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule